// File: doc/BRIEF.md
# Flash Completion Polling Engine

This block runs on the host side of a NOR flash. Once software or another engine has sent a program or erase command to the device, this engine decides whether the operation succeeded. It repeatedly reads one status location and applies a fixed decision algorithm to each byte that comes back. It then reports a single result: pass, fail, or fail by timeout. On a failure it also raises a one-cycle request so that a neighbour can send the device its reset command.

Two checking methods are available. The first watches the completion bit (bit 7) and compares it against an expected value. That value is 1 after an erase, because erased cells read as 1, and it is bit 7 of the written byte after a program. The second method watches whether bit 6 changes between consecutive reads. In both methods the error flag (bit 5) is not taken as final, because the device may finish between two reads. When bit 5 is seen, the engine makes confirmation reads before it decides.

Reads go out as address requests on a valid/ready channel. Read data returns on a second valid/ready channel. Only one read is outstanding at a time. A request holds its address stable until it is accepted. The response channel asserts ready only while a read is pending, so the memory side may stall either channel for any number of cycles.

Top module: `flash_poll_engine`

## Requirements
- R1: After reset, rd_valid, rsp_ready, busy, done, pass, fail, timeout and reset_req are all 0.
- R2: A read request keeps rd_valid high and rd_addr stable until rd_ready is seen. rd_addr equals check_addr as captured at start. rsp_ready is high only between an accepted request and its response, so at most one read is outstanding and rd_valid is never high while rsp_ready is high.
- R3: In data-polling mode (mode_toggle=0), a read whose bit 7 equals the expected value ends the run with pass. The expected value is 1 when op_erase=1, and prog_data[7] otherwise.
- R4: In data-polling mode, a read whose bit 7 differs from the expected value while bit 5 is 0 leads to another read.
- R5: In data-polling mode, a read whose bit 7 differs while bit 5 is 1 leads to exactly one more read. If bit 7 of that read matches, the result is pass; otherwise it is fail.
- R6: In toggle mode (mode_toggle=1), the first read is only a reference. Each later read whose bit 6 equals bit 6 of the previous read ends with pass. If bit 6 differs and bit 5 is 0, the engine makes another read.
- R7: In toggle mode, a read with bit 6 changed and bit 5 at 1 leads to two more reads. If bit 6 differs between those two reads, the result is fail; otherwise it is pass.
- R8: A run never makes more than max_polls reads (captured at start). When the algorithm needs another read and max_polls reads are already done, the run ends with fail and timeout=1. This includes max_polls=0, which ends with no read.
- R9: done is a one-cycle pulse. With it, exactly one of pass or fail is 1, and timeout implies fail. pass, fail and timeout hold until the next accepted start.
- R10: reset_req pulses for one cycle together with done, exactly when the result is fail.
- R11: busy is high from an accepted start until done. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a check run; taken only when idle |
| mode_toggle | input | 1 | 0 = completion-bit polling, 1 = toggle checking |
| op_erase | input | 1 | 1 if the checked operation was an erase |
| prog_data | input | 8 | Byte that was programmed |
| check_addr | input | ADDR_W | Programmed address, or any address in the erased block |
| max_polls | input | CNT_W | Read budget for the run |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read request address |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Engine waiting for read data |
| rsp_data | input | 8 | Read data byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result: operation succeeded |
| fail | output | 1 | Result: operation failed or timed out |
| timeout | output | 1 | Result: read budget ran out |
| reset_req | output | 1 | One-cycle request to send the reset command |

## Verification
The assertions check the interface and result rules on every cycle:
- a stalled request holds its address, and requests and pending responses never overlap;
- done lasts one cycle and carries exactly one verdict;
- reset_req appears only with a failing done;
- the number of accepted reads stays within the captured budget.

The decision algorithm itself can only be shown by the bench's scripted status sequences. These cover late completion after the error flag, a confirmed failure in each mode, toggle settling during confirmation, and timeouts on both a normal poll and a confirmation read. The bench also applies random back-pressure on both channels and checks that a start pulse during a run is ignored.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int DQ_W    = 8;
  localparam int BIT_CMP = 7;
  localparam int BIT_TOG = 6;
  localparam int BIT_ERR = 5;

  typedef enum logic [2:0] {
    PH_DP_MAIN,
    PH_DP_CONF,
    PH_TG_FIRST,
    PH_TG_MAIN,
    PH_TG_CONF_A,
    PH_TG_CONF_B
  } phase_e;

  typedef enum logic [1:0] {
    ACT_READ,
    ACT_PASS,
    ACT_FAIL
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT
  } eng_st_e;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_REQ,
    RD_RSP
  } rd_st_e;
endpackage

// File: rtl/poll_reader.sv
module poll_reader
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DQ_W-1:0]   rsp_data,
  output logic              got,
  output logic [DQ_W-1:0]   got_data
);
  rd_st_e            st;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RD_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st)
        RD_IDLE: if (go) begin
          addr_q <= addr;
          st     <= RD_REQ;
        end
        RD_REQ:  if (rd_ready) st <= RD_RSP;
        RD_RSP:  if (rsp_valid) st <= RD_IDLE;
        default: st <= RD_IDLE;
      endcase
    end
  end

  assign rd_valid  = (st == RD_REQ);
  assign rd_addr   = addr_q;
  assign rsp_ready = (st == RD_RSP);
  assign got       = rsp_ready && rsp_valid;
  assign got_data  = rsp_data;
endmodule

// File: rtl/poll_judge.sv
module poll_judge
  import flash_poll_pkg::*;
(
  input  phase_e          phase,
  input  logic [DQ_W-1:0] data,
  input  logic            exp_bit,
  input  logic            prev_tog,
  output act_e            act,
  output phase_e          nxt
);
  logic cmp_ok, tog_same, err;

  assign cmp_ok   = (data[BIT_CMP] == exp_bit);
  assign tog_same = (data[BIT_TOG] == prev_tog);
  assign err      = data[BIT_ERR];

  always_comb begin
    act = ACT_READ;
    nxt = phase;
    unique case (phase)
      PH_DP_MAIN: begin
        if (cmp_ok)   act = ACT_PASS;
        else if (err) nxt = PH_DP_CONF;
      end
      PH_DP_CONF:   act = cmp_ok ? ACT_PASS : ACT_FAIL;
      PH_TG_FIRST:  nxt = PH_TG_MAIN;
      PH_TG_MAIN: begin
        if (tog_same) act = ACT_PASS;
        else if (err) nxt = PH_TG_CONF_A;
      end
      PH_TG_CONF_A: nxt = PH_TG_CONF_B;
      PH_TG_CONF_B: act = tog_same ? ACT_PASS : ACT_FAIL;
      default:      act = ACT_FAIL;
    endcase
  end
endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  input  logic             inc,
  output logic             exhausted
);
  logic [CNT_W-1:0] cnt, lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      lim_q <= '0;
    end else if (clear) begin
      cnt   <= '0;
      lim_q <= limit;
    end else if (inc && !exhausted) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign exhausted = (cnt >= lim_q);
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_toggle,
  input  logic              op_erase,
  input  logic [7:0]        prog_data,
  input  logic [ADDR_W-1:0] check_addr,
  input  logic [CNT_W-1:0]  max_polls,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [7:0]        rsp_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              timeout,
  output logic              reset_req
);
  eng_st_e           st;
  phase_e            phase, nxt;
  act_e              act;
  logic              exp_bit, prev_tog;
  logic [ADDR_W-1:0] addr_q;
  logic              go, got, exhausted, accept;
  logic [DQ_W-1:0]   got_data;

  assign accept = (st == ST_IDLE) && start;
  assign go     = (st == ST_LAUNCH) && !exhausted;
  assign busy   = (st != ST_IDLE);

  poll_reader #(.ADDR_W(ADDR_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .go(go), .addr(addr_q),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .got(got), .got_data(got_data)
  );

  poll_judge u_judge (
    .phase(phase), .data(got_data), .exp_bit(exp_bit), .prev_tog(prev_tog),
    .act(act), .nxt(nxt)
  );

  poll_budget #(.CNT_W(CNT_W)) u_budget (
    .clk(clk), .rst_n(rst_n), .clear(accept), .limit(max_polls),
    .inc(got), .exhausted(exhausted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      phase     <= PH_DP_MAIN;
      exp_bit   <= 1'b0;
      prev_tog  <= 1'b0;
      addr_q    <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      timeout   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      done      <= 1'b0;
      reset_req <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          st      <= ST_LAUNCH;
          phase   <= mode_toggle ? PH_TG_FIRST : PH_DP_MAIN;
          exp_bit <= op_erase ? 1'b1 : prog_data[BIT_CMP];
          addr_q  <= check_addr;
          pass    <= 1'b0;
          fail    <= 1'b0;
          timeout <= 1'b0;
        end
        ST_LAUNCH: begin
          if (exhausted) begin
            st        <= ST_IDLE;
            done      <= 1'b1;
            fail      <= 1'b1;
            timeout   <= 1'b1;
            reset_req <= 1'b1;
          end else begin
            st <= ST_WAIT;
          end
        end
        ST_WAIT: if (got) begin
          prev_tog <= got_data[BIT_TOG];
          unique case (act)
            ACT_PASS: begin
              st   <= ST_IDLE;
              done <= 1'b1;
              pass <= 1'b1;
            end
            ACT_FAIL: begin
              st        <= ST_IDLE;
              done      <= 1'b1;
              fail      <= 1'b1;
              reset_req <= 1'b1;
            end
            default: begin
              phase <= nxt;
              st    <= ST_LAUNCH;
            end
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk #(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  max_polls,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rsp_ready,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic              timeout,
  input logic              reset_req
);
  logic [CNT_W:0]   seen;
  logic [CNT_W-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= '0;
      lim  <= '0;
    end else if (start && !busy) begin
      seen <= '0;
      lim  <= max_polls;
    end else if (rd_valid && rd_ready) begin
      seen <= seen + 1'b1;
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rsp_ready));
  // R8
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= {1'b0, lim});
  // R8
  timeout_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> fail);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));
  // R10
  reset_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> done && fail);
  // R10
  fail_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fail |-> reset_req);
  // R11
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind flash_poll_engine flash_poll_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .max_polls(max_polls),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .rsp_ready(rsp_ready), .busy(busy), .done(done), .pass(pass),
  .fail(fail), .timeout(timeout), .reset_req(reset_req)
);

// File: tb/sim_flash_poll_engine.sv
module sim_flash_poll_engine;
  localparam int ADDR_W = 19;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode_toggle = 1'b0, op_erase = 1'b0;
  logic [7:0] prog_data = '0;
  logic [ADDR_W-1:0] check_addr = '0;
  logic [CNT_W-1:0] max_polls = '0;
  logic rd_valid, rd_ready, rsp_valid, rsp_ready;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0] rsp_data;
  logic busy, done, pass, fail, timeout, reset_req;

  always #2.5 clk = ~clk;

  flash_poll_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (.*);

  typedef struct { bit pass; bit tmo; int reads; string tag; } exp_t;
  exp_t exp_q[$];
  byte  script[$];
  int   checks = 0, errors = 0, reads = 0;
  logic [ADDR_W-1:0] cur_addr = '0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // memory-side responder with random back-pressure on both channels
  initial begin
    int ph = 0, dly = 0;
    rd_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      case (ph)
        0: begin
          rd_ready = ($urandom_range(0, 2) != 0);
          if (rd_valid && rd_ready) begin
            reads++;
            chk(rd_addr == cur_addr, "R2 address", rd_addr, cur_addr);
            dly = $urandom_range(0, 2);
            ph = 1;
          end
        end
        1: begin
          rd_ready = 1'b0;
          if (dly == 0) begin
            rsp_data  = (script.size() != 0) ? script.pop_front() : 8'h00;
            rsp_valid = 1'b1;
            chk(rsp_ready == 1'b1, "R2 rsp_ready", rsp_ready, 1);
            ph = 2;
          end else dly--;
        end
        default: begin
          rsp_valid = 1'b0;
          ph = 0;
        end
      endcase
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(pass == e.pass, {e.tag, " pass"}, pass, e.pass);
          chk(fail == !e.pass, {e.tag, " fail"}, fail, !e.pass);
          chk(timeout == e.tmo, {e.tag, " R8 timeout"}, timeout, e.tmo);
          chk(reset_req == !e.pass, {e.tag, " R10 reset_req"}, reset_req, !e.pass);
          chk(reads == e.reads, {e.tag, " read count"}, reads, e.reads);
          chk(!busy, "R11 busy at done", busy, 0);
        end
      end
    end
  end

  task automatic run_case(input bit tg, input bit er, input byte wd, input int mp,
                          input byte bytes[$], input bit ep, input bit et,
                          input int er_reads, input string tag, input bit poke);
    exp_t e;
    e.pass = ep; e.tmo = et; e.reads = er_reads; e.tag = tag;
    script = bytes;
    exp_q.push_back(e);
    @(negedge clk);
    reads = 0;
    cur_addr = ADDR_W'($urandom);
    check_addr = cur_addr;
    mode_toggle = tg; op_erase = er; prog_data = wd; max_polls = CNT_W'(mp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_addr = '0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R11 busy during run", busy, 1);
      mode_toggle = ~tg; op_erase = 1'b1; max_polls = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(pass == ep && fail == !ep, "R9 result held", {pass, fail}, {ep, !ep});
    chk(done == 1'b0 && reset_req == 1'b0, "R9 done one cycle", {done, reset_req}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({rd_valid, rsp_ready, busy, done, pass, fail, timeout, reset_req} == 8'h00,
        "R1 reset state", {rd_valid, rsp_ready, busy, done, pass, fail, timeout, reset_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3/R4: program with bit 7 = 1, completes on third read
    run_case(0, 0, 8'h80, 10, '{8'h00, 8'h00, 8'h80}, 1, 0, 3, "R3 R4 dp program", 0);
    // R3: erase expects 1, immediate
    run_case(0, 1, 8'h00, 10, '{8'h80}, 1, 0, 1, "R3 dp erase", 0);
    // R3: program with bit 7 = 0 matches on first read
    run_case(0, 0, 8'h11, 10, '{8'h00}, 1, 0, 1, "R3 dp exp0", 0);
    // R5: error flag, then completion on confirmation read
    run_case(0, 1, 8'h00, 10, '{8'h20, 8'h80}, 1, 0, 2, "R5 late pass", 0);
    // R5: error flag confirmed
    run_case(0, 0, 8'h00, 10, '{8'hA0, 8'hA0}, 0, 0, 2, "R5 confirmed fail", 0);
    // R6: toggling then stable; start pulse during run ignored (R11)
    run_case(1, 0, 8'h00, 10, '{8'h00, 8'h40, 8'h40}, 1, 0, 3, "R6 R11 toggle settle", 1);
    // R6: stable on first compare
    run_case(1, 1, 8'h00, 10, '{8'h44, 8'h44}, 1, 0, 2, "R6 toggle immediate", 0);
    // R7: toggling with error flag, still toggling -> fail
    run_case(1, 1, 8'h00, 10, '{8'h00, 8'h60, 8'h00, 8'h40}, 0, 0, 4, "R7 toggle fail", 0);
    // R7: toggling with error flag, then stops -> pass
    run_case(1, 1, 8'h00, 10, '{8'h00, 8'h60, 8'h40, 8'h40}, 1, 0, 4, "R7 toggle late pass", 0);
    // R8: budget runs out during normal polling
    run_case(0, 1, 8'h00, 3, '{8'h00, 8'h00, 8'h00}, 0, 1, 3, "R8 timeout", 0);
    // R8: zero budget, no read
    run_case(0, 1, 8'h00, 0, '{}, 0, 1, 0, "R8 zero budget", 0);
    // R8: budget runs out before confirmation read
    run_case(0, 1, 8'h00, 1, '{8'h20}, 0, 1, 1, "R8 timeout at confirm", 0);
    // R8: toggle budget exhausted
    run_case(1, 0, 8'h00, 2, '{8'h00, 8'h40}, 0, 1, 2, "R8 toggle timeout", 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - errors, checks);
    $finish;
  end
endmodule